// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C bus master. The host starts a byte with a one-cycle receive strobe. The block then runs its own half-period timer, which it reloads from a host-supplied value. Each time the timer expires, SCL changes level. On every low-to-high change of SCL, the block shifts the level on SDA into an internal register, most significant bit first. When the eighth SCL low phase begins, the byte moves to a buffer the host can read. At the same moment the block raises a buffer-full flag and pulses an interrupt. It then goes back to idle with SCL held low and the timer stopped.

After the byte, the host can request an acknowledge phase with a separate strobe, together with the level to drive: 0 for acknowledge, 1 for not-acknowledge. Three flags guard the buffer, and each has its own rules for setting and clearing. The full flag is set when a byte is loaded and cleared when the host reads. The overflow flag is set when a byte completes while the buffer is still full. The collision flag is set when the host writes the buffer while a byte is being shifted in. Overflow and collision stay set until the host clears them with a dedicated strobe.

Top module: `i2c_rx_master`

## Requirements
- R1: A receive strobe `rx_start_i` seen while the block is idle makes `rx_busy_o` high one cycle later. A receive or acknowledge strobe seen while either sequence is active is ignored. If both strobes arrive together while idle, reception is started.
- R2: During reception, SCL starts low and changes level each time `reload_i`+1 clocks have passed. A byte uses exactly 16 SCL changes, so `rx_busy_o` stays high for 16*(`reload_i`+1) cycles. `sda_o` stays 1 for the whole byte.
- R3: On each SCL low-to-high change, SDA is shifted in. The first bit sampled becomes bit 7 of the byte and the last becomes bit 0.
- R4: On the eighth SCL high-to-low change, `rx_busy_o` clears and `irq_o` is high for exactly one cycle. SCL then stays low, and nothing changes on it until the next strobe.
- R5: If a byte completes while `full_o` is 0, the byte appears on `rd_data_o` and `full_o` goes to 1. A read strobe `rd_i` clears `full_o`, except in a cycle where a new byte is being loaded.
- R6: If a byte completes while `full_o` is 1, `ov_o` is set, the new byte is dropped, `rd_data_o` keeps the old byte, and `full_o` stays 1. `ov_o` stays set until `clr_ov_i` is pulsed.
- R7: A write `wr_i` while `rx_busy_o` is high sets `wcol_o` and leaves `rd_data_o` unchanged. `wcol_o` stays set until `clr_wcol_i` is pulsed. A write at any other time loads `wr_data_i` into the buffer and leaves `full_o` unchanged.
- R8: An acknowledge strobe while idle drives `sda_o` to `ack_val_i` for the whole phase. SCL stays low for `reload_i`+1 cycles, then high for `reload_i`+1 cycles, then returns low. At that last change, `ack_busy_o` clears and `sda_o` returns to 1.
- R9: After reset the outputs are: SCL low, SDA high, both busy outputs 0, all flags 0, `irq_o` 0, and `rd_data_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reload_i | input | DIV_W | Half-period reload value; one half-period is reload+1 clocks |
| rx_start_i | input | 1 | One-cycle strobe that starts reception of a byte |
| ack_start_i | input | 1 | One-cycle strobe that starts the acknowledge phase |
| ack_val_i | input | 1 | Level driven during acknowledge: 0 for ACK, 1 for NACK |
| rd_i | input | 1 | Host read of the buffer; clears the full flag |
| wr_i | input | 1 | Host write of the buffer |
| wr_data_i | input | 8 | Data for a host write |
| clr_ov_i | input | 1 | Clears the overflow flag |
| clr_wcol_i | input | 1 | Clears the collision flag |
| sda_i | input | 1 | Sampled SDA line |
| scl_o | output | 1 | SCL drive level |
| sda_o | output | 1 | SDA drive level (1 = released) |
| rx_busy_o | output | 1 | Reception active; clears itself at the end of the byte |
| ack_busy_o | output | 1 | Acknowledge phase active; clears itself at its end |
| rd_data_o | output | 8 | Buffer contents |
| full_o | output | 1 | Buffer holds an unread byte |
| ov_o | output | 1 | Sticky overflow flag |
| wcol_o | output | 1 | Sticky write-collision flag |
| irq_o | output | 1 | One-cycle pulse when a byte completes |

## Verification
Every output is a register. A strobe applied before clock edge N therefore shows up right after edge N: the busy outputs, the collision flag, the flag clears and idle writes all appear in that one-edge window. SCL changes land reload+1 edges apart. The byte result (buffer, full, overflow, interrupt) lands 16*(reload+1) edges after the receive strobe. A behavioural model in the bench follows these same latencies and is compared against every output, shortly after each rising edge. Directed checks sample at falling edges and count busy cycles and SCL changes, so the timing is confirmed without relying on the RTL's counters.

// File: rtl/i2c_rx_master.sv
module i2c_rx_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload_i,
  input  logic             rx_start_i,
  input  logic             ack_start_i,
  input  logic             ack_val_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             clr_ov_i,
  input  logic             clr_wcol_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             rx_busy_o,
  output logic             ack_busy_o,
  output logic [7:0]       rd_data_o,
  output logic             full_o,
  output logic             ov_o,
  output logic             wcol_o,
  output logic             irq_o
);
  localparam int BITS  = 8;
  localparam int HALVES = 2 * BITS;
  localparam int HW    = $clog2(HALVES);

  typedef enum logic [1:0] {IDLE, RX, ACK} mode_t;

  mode_t            mode;
  logic [DIV_W-1:0] cnt;
  logic [HW-1:0]    half;
  logic [BITS-1:0]  shreg;
  logic [BITS-1:0]  buffer;

  wire tick     = (mode != IDLE) && (cnt == '0);
  wire rx_done  = (mode == RX)  && tick && (half == HW'(HALVES - 1));
  wire ack_done = (mode == ACK) && tick && (half == HW'(1));
  wire load     = rx_done && !full_o;

  assign rx_busy_o  = (mode == RX);
  assign ack_busy_o = (mode == ACK);
  assign rd_data_o  = buffer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= IDLE;
      cnt   <= '0;
      half  <= '0;
      scl_o <= 1'b0;
      sda_o <= 1'b1;
      shreg <= '0;
    end else begin
      case (mode)
        IDLE: begin
          if (rx_start_i) begin
            mode  <= RX;
            cnt   <= reload_i;
            half  <= '0;
            sda_o <= 1'b1;
          end else if (ack_start_i) begin
            mode  <= ACK;
            cnt   <= reload_i;
            half  <= '0;
            sda_o <= ack_val_i;
          end
        end
        default: begin
          if (tick) begin
            cnt   <= reload_i;
            half  <= half + 1'b1;
            scl_o <= ~scl_o;
            if (!scl_o && mode == RX)
              shreg <= {shreg[BITS-2:0], sda_i};
            if (rx_done || ack_done) begin
              mode  <= IDLE;
              sda_o <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buffer <= '0;
      full_o <= 1'b0;
      ov_o   <= 1'b0;
      wcol_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o  <= rx_done;
      full_o <= load | (full_o & ~rd_i);
      ov_o   <= (rx_done & full_o) | (ov_o & ~clr_ov_i);
      wcol_o <= (wr_i & rx_busy_o) | (wcol_o & ~clr_wcol_i);
      if (load)
        buffer <= shreg;
      else if (wr_i && !rx_busy_o)
        buffer <= wr_data_i;
    end
  end
endmodule

// File: rtl/i2c_rx_master_chk.sv
module i2c_rx_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_start_i,
  input logic       wr_i,
  input logic       rx_busy_o,
  input logic       ack_busy_o,
  input logic       scl_o,
  input logic       sda_o,
  input logic       irq_o,
  input logic       full_o,
  input logic       ov_o,
  input logic       wcol_o,
  input logic [7:0] rd_data_o
);
  // R1
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_busy_o && !ack_busy_o && rx_start_i) |=> rx_busy_o);
  // R1
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_busy_o && rx_start_i) |=> !rx_busy_o);
  // R2
  sda_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy_o |-> sda_o);
  // R4
  idle_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_busy_o && !ack_busy_o) |-> !scl_o);
  // R4
  end_of_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_busy_o) |-> (irq_o && !scl_o));
  // R5
  irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> full_o);
  // R6
  overflow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_o) |-> $stable(rd_data_o));
  // R7
  collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy_o && wr_i) |=> wcol_o);
  // R8
  ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_busy_o) |-> (sda_o && !scl_o));
endmodule

bind i2c_rx_master i2c_rx_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_start_i(rx_start_i), .wr_i(wr_i),
  .rx_busy_o(rx_busy_o), .ack_busy_o(ack_busy_o), .scl_o(scl_o),
  .sda_o(sda_o), .irq_o(irq_o), .full_o(full_o), .ov_o(ov_o),
  .wcol_o(wcol_o), .rd_data_o(rd_data_o)
);

// File: tb/i2c_rx_master_tb_top.sv
module i2c_rx_master_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] reload_i = 8'd2;
  logic rx_start_i = 0, ack_start_i = 0, ack_val_i = 0;
  logic rd_i = 0, wr_i = 0, clr_ov_i = 0, clr_wcol_i = 0;
  logic [7:0] wr_data_i = 0;
  logic sda_i;
  logic scl_o, sda_o, rx_busy_o, ack_busy_o, full_o, ov_o, wcol_o, irq_o;
  logic [7:0] rd_data_o;

  always #5 clk = ~clk;

  i2c_rx_master #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reload_i(reload_i), .rx_start_i(rx_start_i),
    .ack_start_i(ack_start_i), .ack_val_i(ack_val_i), .rd_i(rd_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .clr_ov_i(clr_ov_i), .clr_wcol_i(clr_wcol_i),
    .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .rx_busy_o(rx_busy_o),
    .ack_busy_o(ack_busy_o), .rd_data_o(rd_data_o), .full_o(full_o),
    .ov_o(ov_o), .wcol_o(wcol_o), .irq_o(irq_o));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave side: presents bits MSB first, advancing after each SCL rise
  logic [7:0] tx_byte = 0;
  int idx = 8;
  always @(posedge scl_o) idx++;
  assign sda_i = (idx < 8) ? tx_byte[7 - idx] : 1'b1;

  // behavioural reference, compared shortly after every rising edge
  int m_mode, m_cnt, m_half;
  bit m_scl, m_sda, m_full, m_ov, m_wcol, m_irq, t_tick, t_rdone, t_adone, t_ld;
  logic [7:0] m_sh, m_buf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_half = 0; m_scl = 0; m_sda = 1;
      m_full = 0; m_ov = 0; m_wcol = 0; m_irq = 0; m_sh = 0; m_buf = 0;
    end else begin
      t_tick  = (m_mode != 0) && (m_cnt == 0);
      t_rdone = t_tick && m_mode == 1 && m_half == 15;
      t_adone = t_tick && m_mode == 2 && m_half == 1;
      t_ld    = t_rdone && !m_full;
      m_irq   = t_rdone;
      if (t_ld) m_buf = m_sh;
      else if (wr_i && m_mode != 1) m_buf = wr_data_i;
      m_ov   = (t_rdone && m_full) || (m_ov && !clr_ov_i);
      m_wcol = (wr_i && m_mode == 1) || (m_wcol && !clr_wcol_i);
      m_full = t_ld || (m_full && !rd_i);
      if (m_mode == 0) begin
        if (rx_start_i) begin m_mode = 1; m_cnt = reload_i; m_half = 0; m_sda = 1; end
        else if (ack_start_i) begin m_mode = 2; m_cnt = reload_i; m_half = 0; m_sda = ack_val_i; end
      end else if (t_tick) begin
        m_cnt = reload_i;
        m_half++;
        if (!m_scl && m_mode == 1) m_sh = {m_sh[6:0], sda_i};
        m_scl = !m_scl;
        if (t_rdone || t_adone) begin m_mode = 0; m_sda = 1; end
      end else m_cnt--;
    end
    #2;
    if (rst_n) begin
      chk(scl_o == m_scl, "R2 scl", scl_o, m_scl);
      chk(sda_o == m_sda, "R8 sda", sda_o, m_sda);
      chk(rx_busy_o == (m_mode == 1), "R1 rx_busy", rx_busy_o, m_mode == 1);
      chk(ack_busy_o == (m_mode == 2), "R8 ack_busy", ack_busy_o, m_mode == 2);
      chk(rd_data_o == m_buf, "R3 rd_data", rd_data_o, m_buf);
      chk(full_o == m_full, "R5 full", full_o, m_full);
      chk(ov_o == m_ov, "R6 ov", ov_o, m_ov);
      chk(wcol_o == m_wcol, "R7 wcol", wcol_o, m_wcol);
      chk(irq_o == m_irq, "R4 irq", irq_o, m_irq);
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  // receive one byte; optional poke cycles for mid-byte strobes/writes
  task automatic get_byte(input logic [7:0] b, input int poke_start, input int poke_wr,
                          output int busy, output int tog, output bit irq_end, output bit ack_seen);
    logic prev;
    tx_byte = b; idx = 0; ack_seen = 0;
    @(negedge clk); rx_start_i = 1;
    @(negedge clk); rx_start_i = 0;
    busy = 0; tog = 0; prev = scl_o;
    while (rx_busy_o && busy < 5000) begin
      busy++;
      rx_start_i  = (busy == poke_start);
      ack_start_i = (busy == poke_start);
      wr_i        = (busy == poke_wr);
      wr_data_i   = 8'hEE;
      @(negedge clk);
      rx_start_i = 0; ack_start_i = 0; wr_i = 0;
      if (ack_busy_o) ack_seen = 1;
      if (scl_o != prev) tog++;
      prev = scl_o;
    end
    irq_end = irq_o;
  endtask

  int busy, tog, hi;
  bit irq_end, ack_seen;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!scl_o && sda_o && !rx_busy_o && !ack_busy_o, "R9 lines", {scl_o, sda_o, rx_busy_o, ack_busy_o}, 4'b0100);
    chk({full_o, ov_o, wcol_o, irq_o} == 0 && rd_data_o == 0, "R9 flags", {full_o, ov_o, wcol_o, irq_o, rd_data_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    reload_i = 8'd2;
    get_byte(8'hA5, -1, -1, busy, tog, irq_end, ack_seen);
    chk(busy == 48, "R2 byte length", busy, 48);
    chk(tog == 16, "R2 scl changes", tog, 16);
    chk(irq_end, "R4 irq at end", irq_end, 1);
    chk(rd_data_o == 8'hA5, "R3 byte value", rd_data_o, 8'hA5);
    chk(full_o, "R5 full set", full_o, 1);
    @(negedge clk);
    chk(!irq_o && !scl_o, "R4 one-cycle irq, scl low", {irq_o, scl_o}, 0);
    repeat (10) @(negedge clk);
    chk(!scl_o && !rx_busy_o, "R4 parked", {scl_o, rx_busy_o}, 0);

    // second byte while full -> overflow, strobes mid-byte ignored
    get_byte(8'h3C, 7, -1, busy, tog, irq_end, ack_seen);
    chk(busy == 48, "R1 restart ignored", busy, 48);
    chk(!ack_seen, "R1 ack strobe ignored", ack_seen, 0);
    chk(ov_o && full_o, "R6 overflow set", {ov_o, full_o}, 2'b11);
    chk(rd_data_o == 8'hA5, "R6 old byte kept", rd_data_o, 8'hA5);
    repeat (5) @(negedge clk);
    chk(ov_o, "R6 sticky", ov_o, 1);
    pulse(clr_ov_i);
    chk(!ov_o, "R6 cleared", ov_o, 0);
    pulse(rd_i);
    chk(!full_o, "R5 read clears", full_o, 0);

    // write during reception -> collision
    get_byte(8'h5A, -1, 20, busy, tog, irq_end, ack_seen);
    chk(wcol_o, "R7 collision", wcol_o, 1);
    chk(rd_data_o == 8'h5A, "R7 write dropped", rd_data_o, 8'h5A);
    pulse(clr_wcol_i);
    chk(!wcol_o, "R7 cleared", wcol_o, 0);
    @(negedge clk); wr_data_i = 8'h77; wr_i = 1;
    @(negedge clk); wr_i = 0;
    chk(rd_data_o == 8'h77 && full_o, "R7 idle write", rd_data_o, 8'h77);
    pulse(rd_i);

    // acknowledge phases
    for (int v = 0; v < 2; v++) begin
      ack_val_i = v[0];
      @(negedge clk); ack_start_i = 1;
      @(negedge clk); ack_start_i = 0;
      busy = 0; hi = 0;
      while (ack_busy_o && busy < 1000) begin
        busy++;
        chk(sda_o == v[0], "R8 ack level", sda_o, v);
        if (scl_o) hi++;
        @(negedge clk);
      end
      chk(busy == 6 && hi == 3, "R8 ack timing", busy * 16 + hi, 6 * 16 + 3);
      chk(sda_o && !scl_o, "R8 release", {sda_o, scl_o}, 2'b10);
    end

    // both strobes together, fastest divider
    reload_i = 8'd0;
    tx_byte = 8'h01; idx = 0;
    @(negedge clk); rx_start_i = 1; ack_start_i = 1;
    @(negedge clk); rx_start_i = 0; ack_start_i = 0;
    chk(rx_busy_o && !ack_busy_o, "R1 receive wins", {rx_busy_o, ack_busy_o}, 2'b10);
    busy = 0;
    while (rx_busy_o && busy < 1000) begin busy++; @(negedge clk); end
    chk(busy == 16, "R2 reload zero", busy, 16);
    chk(rd_data_o == 8'h01, "R3 lsb last", rd_data_o, 8'h01);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule